// File: doc/BRIEF.md
# Antifuse OTP Byte Memory Controller

This block sequences a one-time-programmable byte memory of 128 rows by 8 bits. It has separate input and output data ports, a 7-bit row address and two strobes, one to program and one to read. A write burns a whole row in one operation. Each 0 in the input byte blows a cell, and each 1 leaves its cell alone. A read runs a fixed timed sequence on the selected row and returns the byte on the output port. A cell that has been programmed reads as 0, and a blank cell reads as 1.

The strobes are asynchronous to the block. They pass through a two-flop synchronizer, and an operation starts on the synchronized rising edge of its strobe. The address, and the data for a write, must already be stable at that edge. A small FSM on the system clock produces the timing. Parameters set the length of the programming window, of the precharge, of the word-line-to-sense delay and of the sense-to-latch delay.

The cell array is a register model in which bits only ever move from 1 to 0. The analog drivers and sense circuits are out of scope. They appear only as the digital enables this block produces: write word lines, read word lines, the positive and negative line drive enables, precharge and sense enable.

Top module: `otpByteCtrl`

## Requirements
- R1: After reset every write word line is high (inactive), every read word line is low, precharge is low, sense enable is high (inactive), both drive enables are 0, dataValid is 0 and dataOut is 8'hFF.
- R2: Every row of a blank array reads back as 8'hFF.
- R3: A program operation sets the stored row to its old value ANDed with dataIn. A 1 bit never restores a programmed 0, so reprogramming has no effect on bits that are already 0.
- R4: During a program operation, only the write word line of the addressed row is low. It stays low for PROG_CYC cycles, and all read word lines stay low.
- R5: During programming, posDrv and negDrv both equal the bitwise inverse of the captured dataIn, so a 0 data bit enables both drives. Outside programming both are 0.
- R6: A read asserts precharge for exactly PRE_CYC cycles. It then holds the addressed read word line high (one-hot) for WL_CYC cycles with sense enable high, followed by SA_CYC more cycles with sense enable low (active). Precharge never overlaps a read word line.
- R7: dataValid is 0 from the first precharge cycle of a read. It rises once dataOut holds the addressed row, and it stays high with dataOut stable until the next read starts.
- R8: dataIn is ignored during a read: changing it while a read is in progress alters neither the array nor dataOut.
- R9: If one strobe rises while the other is high, including both rising together, strobeErr pulses for one cycle and no word line or drive enable is activated.
- R10: Program-phase outputs (a low write word line or a nonzero drive enable) never occur in the same cycle as read-phase outputs (precharge, a high read word line or an active sense enable).
- R11: progDone pulses high for exactly one cycle, in the cycle after the array row has been updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Row address, stable at the strobe edge |
| dataIn | input | 8 | Program data; a 0 bit burns the cell |
| progStb | input | 1 | Asynchronous program strobe, rising edge starts a write |
| readStb | input | 1 | Asynchronous read strobe, rising edge starts a read |
| dataOut | output | 8 | Byte latched by the last read |
| dataValid | output | 1 | dataOut holds the result of the last read |
| progDone | output | 1 | One-cycle pulse after a row is programmed |
| strobeErr | output | 1 | One-cycle pulse when the strobes conflict |
| wwlN | output | 128 | Active-low write word lines, one per row |
| rwl | output | 128 | Active-high read word lines, one per row |
| posDrv | output | 8 | Per-bit enable of the high positive line drive |
| negDrv | output | 8 | Per-bit enable of the negative line drive |
| prechg | output | 1 | Bit-line precharge pulse |
| senseEnN | output | 1 | Active-low sense amplifier enable |

## Verification
The assertions assume the strobes and the address come out of reset low and stable. They also assume no strobe edge is relied upon while an operation is still in flight, because edges that arrive while the FSM is busy are dropped. The stimulus therefore applies the address and data a cycle before raising a strobe, waits for progDone or dataValid, and then lowers the strobe with idle cycles after it. The conflict case is the one exception: both strobes are raised together on purpose, only while the block is idle. During reads, dataIn is randomized on purpose to exercise the ignore rule.

// File: rtl/otpPkg.sv
package otpPkg;
  typedef struct packed {
    logic capProg;   // latch row and data for a write
    logic capRead;   // latch row for a read
    logic progOn;    // programming window
    logic preOn;     // precharge phase
    logic wlOn;      // read word line active
    logic saOn;      // sense enable active
    logic commit;    // update array row
    logic latch;     // load output register
  } ctlStrobes_t;
endpackage

// File: rtl/otpCtrl.sv
module otpCtrl
  import otpPkg::*;
#(
  parameter int PROG_CYC = 4,
  parameter int PRE_CYC  = 2,
  parameter int WL_CYC   = 3,
  parameter int SA_CYC   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        progStb,
  input  logic        readStb,
  output ctlStrobes_t stb,
  output logic        dataValid,
  output logic        progDone,
  output logic        strobeErr
);
  localparam int MAXC = (PROG_CYC > PRE_CYC ? PROG_CYC : PRE_CYC) > (WL_CYC > SA_CYC ? WL_CYC : SA_CYC)
                      ? (PROG_CYC > PRE_CYC ? PROG_CYC : PRE_CYC) : (WL_CYC > SA_CYC ? WL_CYC : SA_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_PRE, S_WL, S_SENSE} state_t;
  state_t state, nextState;
  logic [CW-1:0] cnt;

  logic [2:0] progSync, readSync;
  logic progRise, readRise, startProg, startRead, conflict, lastCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progSync <= '0;
      readSync <= '0;
    end else begin
      progSync <= {progSync[1:0], progStb};
      readSync <= {readSync[1:0], readStb};
    end
  end

  assign progRise  = progSync[1] & ~progSync[2];
  assign readRise  = readSync[1] & ~readSync[2];
  assign conflict  = (state == S_IDLE) && ((progRise && readSync[1]) || (readRise && progSync[1]));
  assign startProg = (state == S_IDLE) && progRise && !readSync[1];
  assign startRead = (state == S_IDLE) && readRise && !progSync[1];

  always_comb begin
    case (state)
      S_PROG:  lastCyc = (cnt == CW'(PROG_CYC - 1));
      S_PRE:   lastCyc = (cnt == CW'(PRE_CYC - 1));
      S_WL:    lastCyc = (cnt == CW'(WL_CYC - 1));
      S_SENSE: lastCyc = (cnt == CW'(SA_CYC - 1));
      default: lastCyc = 1'b0;
    endcase
  end

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:  if (startProg) nextState = S_PROG;
               else if (startRead) nextState = S_PRE;
      S_PROG:  if (lastCyc) nextState = S_IDLE;
      S_PRE:   if (lastCyc) nextState = S_WL;
      S_WL:    if (lastCyc) nextState = S_SENSE;
      S_SENSE: if (lastCyc) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      dataValid <= 1'b0;
      progDone  <= 1'b0;
      strobeErr <= 1'b0;
    end else begin
      state     <= nextState;
      cnt       <= (nextState != state) ? '0 : cnt + 1'b1;
      progDone  <= stb.commit;
      strobeErr <= conflict;
      if (startRead)      dataValid <= 1'b0;
      else if (stb.latch) dataValid <= 1'b1;
    end
  end

  always_comb begin
    stb         = '0;
    stb.capProg = startProg;
    stb.capRead = startRead;
    stb.progOn  = (state == S_PROG);
    stb.preOn   = (state == S_PRE);
    stb.wlOn    = (state == S_WL) || (state == S_SENSE);
    stb.saOn    = (state == S_SENSE);
    stb.commit  = (state == S_PROG) && lastCyc;
    stb.latch   = (state == S_SENSE) && lastCyc;
  end
endmodule

// File: rtl/otpDatapath.sv
module otpDatapath
  import otpPkg::*;
#(
  parameter int ROWS  = 128,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [$clog2(ROWS)-1:0]  addr,
  input  logic [WIDTH-1:0]         dataIn,
  input  ctlStrobes_t              stb,
  output logic [WIDTH-1:0]         dataOut,
  output logic [ROWS-1:0]          wwlN,
  output logic [ROWS-1:0]          rwl,
  output logic [WIDTH-1:0]         posDrv,
  output logic [WIDTH-1:0]         negDrv,
  output logic                     prechg,
  output logic                     senseEnN
);
  localparam int AW = $clog2(ROWS);

  logic [AW-1:0]    rowQ;
  logic [WIDTH-1:0] dataQ;
  logic [WIDTH-1:0] cells [ROWS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ  <= '0;
      dataQ <= '1;
    end else begin
      if (stb.capProg || stb.capRead) rowQ <= addr;
      if (stb.capProg) dataQ <= dataIn;
    end
  end

  // One-way cell model: bits only fall from 1 to 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '1;
    end else if (stb.commit) begin
      cells[rowQ] <= cells[rowQ] & dataQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dataOut <= '1;
    else if (stb.latch) dataOut <= cells[rowQ];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign wwlN[r] = ~(stb.progOn && (rowQ == AW'(r)));
    assign rwl[r]  = stb.wlOn && (rowQ == AW'(r));
  end

  assign posDrv   = stb.progOn ? ~dataQ : '0;
  assign negDrv   = stb.progOn ? ~dataQ : '0;
  assign prechg   = stb.preOn;
  assign senseEnN = ~stb.saOn;
endmodule

// File: rtl/otpByteCtrl.sv
module otpByteCtrl
  import otpPkg::*;
#(
  parameter int ROWS     = 128,
  parameter int WIDTH    = 8,
  parameter int PROG_CYC = 4,
  parameter int PRE_CYC  = 2,
  parameter int WL_CYC   = 3,
  parameter int SA_CYC   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [$clog2(ROWS)-1:0] addr,
  input  logic [WIDTH-1:0]        dataIn,
  input  logic                    progStb,
  input  logic                    readStb,
  output logic [WIDTH-1:0]        dataOut,
  output logic                    dataValid,
  output logic                    progDone,
  output logic                    strobeErr,
  output logic [ROWS-1:0]         wwlN,
  output logic [ROWS-1:0]         rwl,
  output logic [WIDTH-1:0]        posDrv,
  output logic [WIDTH-1:0]        negDrv,
  output logic                    prechg,
  output logic                    senseEnN
);
  ctlStrobes_t stb;

  otpCtrl #(.PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .WL_CYC(WL_CYC), .SA_CYC(SA_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .progStb(progStb), .readStb(readStb),
    .stb(stb), .dataValid(dataValid), .progDone(progDone), .strobeErr(strobeErr)
  );

  otpDatapath #(.ROWS(ROWS), .WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .stb(stb),
    .dataOut(dataOut), .wwlN(wwlN), .rwl(rwl), .posDrv(posDrv), .negDrv(negDrv),
    .prechg(prechg), .senseEnN(senseEnN)
  );
endmodule

// File: rtl/otpByteCtrlChecker.sv
module otpByteCtrlChecker #(
  parameter int ROWS    = 128,
  parameter int WIDTH   = 8,
  parameter int PRE_CYC = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] dataOut,
  input logic             dataValid,
  input logic             progDone,
  input logic             strobeErr,
  input logic [ROWS-1:0]  wwlN,
  input logic [ROWS-1:0]  rwl,
  input logic [WIDTH-1:0] posDrv,
  input logic [WIDTH-1:0] negDrv,
  input logic             prechg,
  input logic             senseEnN
);
  logic [15:0] preRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       preRun <= '0;
    else if (prechg) preRun <= preRun + 1'b1;
    else             preRun <= '0;
  end

  assert_one_wwl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~wwlN) <= 1);
  assert_rwl_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rwl));
  assert_prechg_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    prechg |-> (rwl == '0));
  assert_sense_on_wl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !senseEnN |-> (rwl != '0));
  assert_prechg_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!prechg && preRun != 0) |-> (preRun == 16'(PRE_CYC)));
  assert_drv_in_prog_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((posDrv != '0) || (negDrv != '0)) |-> !(&wwlN));
  assert_drv_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    posDrv == negDrv);
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(&wwlN) |-> (!prechg && senseEnN && rwl == '0));
  assert_valid_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> (dataValid -> $stable(dataOut)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    progDone |=> !progDone);
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobeErr |-> (&wwlN && rwl == '0 && !prechg));
endmodule

bind otpByteCtrl otpByteCtrlChecker #(.ROWS(ROWS), .WIDTH(WIDTH), .PRE_CYC(PRE_CYC)) uChk (
  .clk(clk), .rstN(rstN), .dataOut(dataOut), .dataValid(dataValid), .progDone(progDone),
  .strobeErr(strobeErr), .wwlN(wwlN), .rwl(rwl), .posDrv(posDrv), .negDrv(negDrv),
  .prechg(prechg), .senseEnN(senseEnN)
);

// File: tb/otpByteCtrl_test.sv
`timescale 1ns/1ps
module otpByteCtrl_test;
  localparam int ROWS = 128, WIDTH = 8;
  localparam int PROG_CYC = 4, PRE_CYC = 2, WL_CYC = 3, SA_CYC = 2;

  logic clk = 0, rstN = 0;
  logic [6:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic progStb = 0, readStb = 0;
  logic [7:0] dataOut, posDrv, negDrv;
  logic dataValid, progDone, strobeErr, prechg, senseEnN;
  logic [127:0] wwlN, rwl;

  int nChecks = 0, nFails = 0;
  int cycles = 0;
  logic [7:0] refMem [ROWS];

  always #2.5 clk = ~clk;

  otpByteCtrl #(.ROWS(ROWS), .WIDTH(WIDTH), .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC),
                .WL_CYC(WL_CYC), .SA_CYC(SA_CYC)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .progStb(progStb), .readStb(readStb),
    .dataOut(dataOut), .dataValid(dataValid), .progDone(progDone), .strobeErr(strobeErr),
    .wwlN(wwlN), .rwl(rwl), .posDrv(posDrv), .negDrv(negDrv), .prechg(prechg), .senseEnN(senseEnN)
  );

  task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] progResult(input logic [7:0] old, input logic [7:0] din);
    return old & din;
  endfunction

  function automatic logic [127:0] rowMask(input logic [6:0] a);
    return 128'd1 << a;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R3 R4 R5 R11 program one row
  task automatic doProg(input logic [6:0] a, input logic [7:0] d);
    int low = 0, waitC = 0;
    logic wlOk = 1, drvOk = 1, doneSeen = 0;
    @(negedge clk);
    addr = a; dataIn = d;
    @(negedge clk);
    progStb = 1;
    while (!doneSeen && waitC < 100) begin
      @(negedge clk);
      waitC++;
      if (!(&wwlN)) begin
        low++;
        if (wwlN != ~rowMask(a) || rwl != '0) wlOk = 0;
        if (posDrv != ~d || negDrv != ~d) drvOk = 0;
      end else if (posDrv != '0 || negDrv != '0) drvOk = 0;
      if (progDone) doneSeen = 1;
    end
    check(doneSeen, "R11 progDone", doneSeen, 1);
    check(wlOk && low == PROG_CYC, "R4 write word line", low, PROG_CYC);
    check(drvOk, "R5 drive enables", posDrv, ~d);
    @(negedge clk);
    check(!progDone, "R11 single pulse", progDone, 0);
    progStb = 0;
    refMem[a] = progResult(refMem[a], d);
    idle(3);
  endtask

  // R2 R6 R7 R8 read one row, scrambling dataIn
  task automatic doRead(input logic [6:0] a);
    int pre = 0, wlOnly = 0, sa = 0, waitC = 0;
    logic seqOk = 1, vSeen = 0, clearOk = 1;
    @(negedge clk);
    addr = a;
    @(negedge clk);
    readStb = 1;
    while (!vSeen && waitC < 100) begin
      @(negedge clk);
      waitC++;
      dataIn = 8'($urandom);
      if (prechg) begin
        pre++;
        if (dataValid) clearOk = 0;
        if (rwl != '0) seqOk = 0;
      end
      if (rwl != '0) begin
        if (rwl != rowMask(a)) seqOk = 0;
        if (senseEnN) begin wlOnly++; if (sa != 0) seqOk = 0; end
        else sa++;
      end else if (!senseEnN) seqOk = 0;
      if (dataValid && pre != 0) vSeen = 1;
    end
    check(clearOk && pre == PRE_CYC, "R7 valid clear / R6 precharge", pre, PRE_CYC);
    check(seqOk && wlOnly == WL_CYC && sa == SA_CYC, "R6 sequence", {wlOnly[7:0], sa[7:0]}, {8'(WL_CYC), 8'(SA_CYC)});
    check(vSeen && dataOut == refMem[a], "R8 R2 R3 readback", dataOut, refMem[a]);
    readStb = 0;
    idle(3);
    check(dataValid && dataOut == refMem[a], "R7 hold", dataOut, refMem[a]);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int r = 0; r < ROWS; r++) refMem[r] = 8'hFF;
    idle(3);
    check(&wwlN && rwl == '0 && !prechg && senseEnN && posDrv == '0 && negDrv == '0,
          "R1 line reset", {wwlN[7:0], rwl[7:0]}, {8'hFF, 8'h00});
    check(!dataValid && dataOut == 8'hFF, "R1 output reset", dataOut, 8'hFF);
    rstN = 1;
    idle(2);

    doRead(7'd0);       // R2 blank
    doRead(7'd127);     // R2 blank
    doProg(7'd0, 8'h00);
    doProg(7'd127, 8'hA5);
    doProg(7'd127, 8'hFF);  // R3 reprogram with ones: no effect
    doProg(7'd127, 8'h5F);  // R3 further burn
    doRead(7'd127);
    doRead(7'd0);

    // R9 conflicting strobes
    begin
      logic errSeen = 0, quiet = 1;
      @(negedge clk);
      addr = 7'd5; dataIn = 8'h00;
      @(negedge clk);
      progStb = 1; readStb = 1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (strobeErr) errSeen = 1;
        if (!(&wwlN) || rwl != '0 || prechg) quiet = 0;
      end
      check(errSeen, "R9 error flag", errSeen, 1);
      check(quiet, "R9 R10 no activity", wwlN[5], 1);
      progStb = 0; readStb = 0;
      idle(3);
      doRead(7'd5);     // R9 row unchanged
    end

    for (int i = 0; i < 60; i++) doProg(7'($urandom), 8'($urandom));
    for (int i = 0; i < 20; i++) begin
      logic [6:0] a = 7'($urandom);
      doProg(a, 8'($urandom) | refMem[a]);
    end
    for (int r = 0; r < ROWS; r++) doRead(7'(r));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule